// File: doc/BRIEF.md
# Clock Output Routing and Postscaler Matrix

This block distributes a set of internal clock sources to six clock outputs. Every output has its own selector that can pick any of the six sources, an integer postscaler with a ratio from 1 to 127, and an optional inversion. All of this logic runs on one fast system clock. The sources and a reference input arrive as level signals that are sampled on that clock, so the block sees each change of a source as a one-cycle event. A source may change at most once per system clock cycle.

Software loads the routing set-up through a plain byte-wide write port. A written value is first held in a staging register. The output that uses it switches to the new value only while that output's divided clock is in its low phase, so no output ever produces a shortened high pulse.

Two external control pins select one of four entries in a small action table, which is also written through the write port. An action can force every output low, release the output enables (high impedance), power the dividers down, or replace every selected source with the reference input.

Top module: `clk_route_matrix`

## Requirements
- R1: Output i takes its source from the 3-bit select field, bits [2:0] of byte 2i+1; values 0 to 5 pick source 0 to 5, and several outputs may share one source. Values 6 and 7 pick no source: that output never toggles and rests at its inversion level.
- R2: The 7-bit postscaler value N (byte 2i, bits [6:0]) gives an output whose high phase and low phase each last N half-periods of the selected source. N = 1 passes the source through unchanged in shape; N = 127 is the largest ratio.
- R3: Odd ratios also give equal high and low phase lengths, with no off-by-one half-period between them.
- R4: The invert bit (bit 3 of byte 2i+1) makes the output the complement of its divided clock.
- R5: A postscaler value of 0 holds the output low.
- R6: The enable bit (bit 4 of byte 2i+1) set to 0 holds that output low.
- R7: Each control-pin code c (0 to 3) looks up a 3-bit action, held at byte 12 + c/2, bits [4*(c%2)+2 : 4*(c%2)]. Action code 1 (force low) drives every clock output to 0 and keeps every output enable at 1 from the next cycle on.
- R8: Action code 2 (high impedance) drops every output enable to 0 from the next cycle on, while the dividers keep running.
- R9: Action code 3 (power down) clears the dividers and drives every clock output and every output enable to 0.
- R10: Action code 4 (bypass) feeds the reference input to every postscaler in place of its selected source. Action code 0 and codes 5 to 7 leave the outputs running normally.
- R11: A new select, ratio, invert or enable value takes effect at an output only while that output's divided clock is low, so every high pulse has the full length of either the old ratio or the new ratio.
- R12: After reset all staging registers and action entries are 0, every clock output is 0 and every output enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that samples all sources |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the set-up registers |
| wr_addr | input | 4 | Byte address of the write |
| wr_data | input | 8 | Byte written |
| ctl_pins | input | 2 | External control code that indexes the action table |
| ref_lvl | input | 1 | Reference clock level, used in bypass |
| src_lvl | input | 6 | Levels of the six internal clock sources |
| out_clk | output | 6 | Clock value of each output |
| out_oe | output | 6 | Output enable of each output (0 means high impedance) |

## Verification
The functions that can land in the same cycle are a register write that changes an output's ratio and that output's own divider toggling into or out of its high phase. The bench times the write two cycles after it sees a rising edge on a running output, so the write arrives while the output is high. It then records the width of every high pulse over the next few hundred cycles and accepts only the full old width or the full new width. A second overlap is a power-down pulse that clears two dividers sharing one source. The bench then requires their normal and inverted outputs to stay exact complements in every cycle.

// File: rtl/cmx_pkg.sv
package cmx_pkg;

    localparam int NSRC  = 6;
    localparam int NOUT  = 6;
    localparam int DIVW  = 7;
    localparam int SELW  = 3;
    localparam int ACTW  = 3;
    localparam int NCTL  = 2;
    localparam int NCODE = 1 << NCTL;

    typedef struct packed {
        logic            en;
        logic            inv;
        logic [SELW-1:0] sel;
        logic [DIVW-1:0] div;
    } route_cfg_t;

    localparam int CFGW = $bits(route_cfg_t);

    typedef enum logic [ACTW-1:0] {
        ACT_RUN    = 3'd0,
        ACT_LOW    = 3'd1,
        ACT_HIZ    = 3'd2,
        ACT_PDOWN  = 3'd3,
        ACT_BYPASS = 3'd4
    } act_e;

    function automatic act_e decode_act(input logic [ACTW-1:0] code);
        case (code)
            3'd1:    return ACT_LOW;
            3'd2:    return ACT_HIZ;
            3'd3:    return ACT_PDOWN;
            3'd4:    return ACT_BYPASS;
            default: return ACT_RUN;
        endcase
    endfunction

    function automatic logic out_level(input route_cfg_t c, input logic ph);
        if (c.en && (c.div != '0))
            return ph ^ c.inv;
        return 1'b0;
    endfunction

endpackage

// File: rtl/cmx_regbank.sv
module cmx_regbank
    import cmx_pkg::*;
#(
    parameter int N_OUT = NOUT,
    parameter int ADDRW = 4,
    parameter int DATAW = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDRW-1:0]            wr_addr,
    input  logic [DATAW-1:0]            wr_data,
    output route_cfg_t [N_OUT-1:0]      stage_cfg,
    output logic [NCODE-1:0][ACTW-1:0]  act_tbl
);

    localparam int TBL_BASE  = 2 * N_OUT;
    localparam int FLD_PITCH = 4;
    localparam int PER_BYTE  = DATAW / FLD_PITCH;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_cfg <= '0;
            act_tbl   <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < N_OUT; i++) begin
                if (wr_addr == ADDRW'(2 * i))
                    stage_cfg[i].div <= wr_data[DIVW-1:0];
                if (wr_addr == ADDRW'(2 * i + 1))
                    {stage_cfg[i].en, stage_cfg[i].inv, stage_cfg[i].sel} <= wr_data[SELW+1:0];
            end
            for (int j = 0; j < NCODE; j++) begin
                if (wr_addr == ADDRW'(TBL_BASE + j / PER_BYTE))
                    act_tbl[j] <= wr_data[(j % PER_BYTE) * FLD_PITCH +: ACTW];
            end
        end
    end

endmodule

// File: rtl/cmx_postscaler.sv
module cmx_postscaler
    import cmx_pkg::*;
#(
    parameter int N_SRC = NSRC
) (
    input  logic             clk,
    input  logic             rst,
    input  route_cfg_t       stage_cfg,
    input  logic [N_SRC-1:0] src_lvl,
    input  logic [N_SRC-1:0] src_prev,
    input  logic             ref_evt,
    input  logic             bypass,
    input  logic             hold,
    output route_cfg_t       live_cfg,
    output logic             phase
);

    logic [DIVW-1:0] cnt;
    logic            sel_lvl;
    logic            sel_prev;
    logic            evt;
    logic            pending;

    always_comb begin
        sel_lvl  = 1'b0;
        sel_prev = 1'b0;
        for (int k = 0; k < N_SRC; k++) begin
            if (live_cfg.sel == SELW'(k)) begin
                sel_lvl  = src_lvl[k];
                sel_prev = src_prev[k];
            end
        end
    end

    assign evt     = bypass ? ref_evt : (sel_lvl ^ sel_prev);
    assign pending = (stage_cfg != live_cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            live_cfg <= '0;
            cnt      <= '0;
            phase    <= 1'b0;
        end else if (hold) begin
            cnt   <= '0;
            phase <= 1'b0;
            if (!phase)
                live_cfg <= stage_cfg;
        end else if (!phase && pending) begin
            live_cfg <= stage_cfg;
            cnt      <= '0;
        end else if (live_cfg.div == '0) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (evt) begin
            if (cnt == live_cfg.div - 1'b1) begin
                cnt   <= '0;
                phase <= ~phase;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cmx_outstage.sv
module cmx_outstage
    import cmx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  route_cfg_t live_cfg,
    input  logic       phase,
    input  act_e       act,
    output logic       clk_q,
    output logic       oe_q
);

    logic lvl;

    assign lvl = out_level(live_cfg, phase);

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q <= 1'b0;
            oe_q  <= 1'b1;
        end else begin
            case (act)
                ACT_LOW: begin
                    clk_q <= 1'b0;
                    oe_q  <= 1'b1;
                end
                ACT_HIZ: begin
                    clk_q <= lvl;
                    oe_q  <= 1'b0;
                end
                ACT_PDOWN: begin
                    clk_q <= 1'b0;
                    oe_q  <= 1'b0;
                end
                default: begin
                    clk_q <= lvl;
                    oe_q  <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/clk_route_matrix.sv
module clk_route_matrix
    import cmx_pkg::*;
#(
    parameter int N_OUT = NOUT,
    parameter int N_SRC = NSRC,
    parameter int ADDRW = 4,
    parameter int DATAW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [ADDRW-1:0] wr_addr,
    input  logic [DATAW-1:0] wr_data,
    input  logic [NCTL-1:0]  ctl_pins,
    input  logic             ref_lvl,
    input  logic [N_SRC-1:0] src_lvl,
    output logic [N_OUT-1:0] out_clk,
    output logic [N_OUT-1:0] out_oe
);

    route_cfg_t [N_OUT-1:0]      stage_cfg;
    route_cfg_t [N_OUT-1:0]      live_cfg;
    logic [NCODE-1:0][ACTW-1:0]  act_tbl;
    logic [N_OUT-1:0]            phase_vec;
    logic [N_OUT*CFGW-1:0]       live_flat;
    logic [N_SRC-1:0]            src_prev;
    logic                        ref_prev;
    logic                        ref_evt;
    act_e                        act;
    logic                        bypass;
    logic                        hold;

    cmx_regbank #(
        .N_OUT (N_OUT),
        .ADDRW (ADDRW),
        .DATAW (DATAW)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .stage_cfg (stage_cfg),
        .act_tbl   (act_tbl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            src_prev <= '0;
            ref_prev <= 1'b0;
        end else begin
            src_prev <= src_lvl;
            ref_prev <= ref_lvl;
        end
    end

    assign ref_evt = ref_lvl ^ ref_prev;
    assign act     = decode_act(act_tbl[ctl_pins]);
    assign bypass  = (act == ACT_BYPASS);
    assign hold    = (act == ACT_PDOWN);
    assign live_flat = live_cfg;

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        cmx_postscaler #(
            .N_SRC (N_SRC)
        ) u_ps (
            .clk       (clk),
            .rst       (rst),
            .stage_cfg (stage_cfg[g]),
            .src_lvl   (src_lvl),
            .src_prev  (src_prev),
            .ref_evt   (ref_evt),
            .bypass    (bypass),
            .hold      (hold),
            .live_cfg  (live_cfg[g]),
            .phase     (phase_vec[g])
        );

        cmx_outstage u_os (
            .clk      (clk),
            .rst      (rst),
            .live_cfg (live_cfg[g]),
            .phase    (phase_vec[g]),
            .act      (act),
            .clk_q    (out_clk[g]),
            .oe_q     (out_oe[g])
        );
    end

endmodule

// File: rtl/clk_route_matrix_chk.sv
module clk_route_matrix_chk
    import cmx_pkg::*;
#(
    parameter int N_OUT = NOUT
) (
    input logic                  clk,
    input logic                  rst,
    input logic [ACTW-1:0]       act,
    input logic [N_OUT-1:0]      out_clk,
    input logic [N_OUT-1:0]      out_oe,
    input logic [N_OUT*CFGW-1:0] live_flat,
    input logic [N_OUT-1:0]      phase_vec
);

    a_r7_force_low: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_LOW) |=> (out_clk == '0) && (&out_oe));

    a_r8_hiz_oe: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_HIZ) |=> (out_oe == '0));

    a_r9_pdown: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_PDOWN) |=> (out_clk == '0) && (out_oe == '0));

    for (genvar i = 0; i < N_OUT; i++) begin : g_a
        a_r11_switch_low: assert property (@(posedge clk) disable iff (rst)
            !$stable(live_flat[i*CFGW +: CFGW]) |-> !$past(phase_vec[i]));

        a_r5_div0_low: assert property (@(posedge clk) disable iff (rst)
            (live_flat[i*CFGW +: DIVW] == '0) |=> !out_clk[i]);
    end

endmodule

bind clk_route_matrix clk_route_matrix_chk #(.N_OUT(N_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .out_clk   (out_clk),
    .out_oe    (out_oe),
    .live_flat (live_flat),
    .phase_vec (phase_vec)
);

// File: tb/clk_route_matrix_tb.sv
module clk_route_matrix_tb;

    localparam int NO = 6;
    localparam int NS = 6;
    localparam int REF_HALF = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [1:0]    ctl_pins = '0;
    logic          ref_lvl = 1'b0;
    logic [NS-1:0] src_lvl = '0;
    logic [NO-1:0] out_clk;
    logic [NO-1:0] out_oe;

    int tests = 0;
    int fails = 0;
    int pushed = 0;
    int served = 0;

    typedef struct {
        int    idx;
        int    hi;
        int    lo;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    clk_route_matrix u_dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ctl_pins (ctl_pins),
        .ref_lvl  (ref_lvl),
        .src_lvl  (src_lvl),
        .out_clk  (out_clk),
        .out_oe   (out_oe)
    );

    // source k: half-period k+2 cycles; reference: half-period REF_HALF
    int scnt[NS];
    int rcnt = 0;
    always @(negedge clk) begin
        for (int k = 0; k < NS; k++) begin
            if (scnt[k] >= k + 1) begin
                scnt[k] = 0;
                src_lvl[k] <= ~src_lvl[k];
            end else begin
                scnt[k] = scnt[k] + 1;
            end
        end
        if (rcnt >= REF_HALF - 1) begin
            rcnt = 0;
            ref_lvl <= ~ref_lvl;
        end else begin
            rcnt = rcnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int actual, input int expected);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 4'(addr);
        wr_data = 8'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic set_out(input int i, input int sel, input int div, input int inv, input int en);
        wr(2 * i, div);
        wr(2 * i + 1, (en << 4) | (inv << 3) | sel);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_period(input int idx, input int hi, input int lo, input string tag);
        exp_t e;
        e.idx = idx;
        e.hi  = hi;
        e.lo  = lo;
        e.tag = tag;
        sb.push_back(e);
        pushed++;
        wait (served == pushed);
    endtask

    task automatic meas(input int idx, output int hi, output int lo);
        @(negedge clk);
        while (out_clk[idx] !== 1'b0) @(negedge clk);
        while (out_clk[idx] !== 1'b1) @(negedge clk);
        hi = 0;
        while (out_clk[idx] === 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (out_clk[idx] === 1'b0) begin lo++; @(negedge clk); end
    endtask

    // monitor: pops expected items and measures the named output
    initial begin
        exp_t e;
        int h;
        int l;
        forever begin
            wait (sb.size() != 0);
            e = sb.pop_front();
            meas(e.idx, h, l);
            meas(e.idx, h, l);
            check(h == e.hi, {e.tag, " high length"}, h, e.hi);
            check(l == e.lo, {e.tag, " low length"}, l, e.lo);
            served++;
        end
    end

    // constant-level check over a window
    task automatic hold_check(input int idx, input logic val, input int n, input string tag);
        int bad = 0;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (out_clk[idx] !== val) bad++;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < NS; k++) scnt[k] = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        check(out_clk == '0, "R12 clocks low after reset", int'(out_clk), 0);
        check(out_oe == 6'h3f, "R12 enables high after reset", int'(out_oe), 'h3f);

        // R7 table: code1 -> low; code2 -> hiz, code3 -> power down
        wr(12, 'h10);
        wr(13, 'h32);

        set_out(0, 2, 1, 0, 1);
        set_out(1, 0, 4, 0, 1);
        set_out(2, 1, 3, 0, 1);
        set_out(3, 0, 3, 0, 1);
        set_out(4, 5, 2, 0, 1);
        set_out(5, 0, 127, 0, 1);
        idle(700);

        expect_period(0, 4, 4, "R2 pass-through src2");
        expect_period(1, 8, 8, "R2 divide 4 src0");
        expect_period(2, 9, 9, "R3 odd divide 3 src1");
        expect_period(3, 6, 6, "R3 odd divide 3 src0");
        expect_period(4, 14, 14, "R1 src5 divide 2");
        expect_period(5, 254, 254, "R2 max divide 127");

        // R4: same source, one inverted; power-down pulse aligns dividers
        set_out(0, 3, 1, 0, 1);
        set_out(1, 3, 1, 1, 1);
        idle(300);
        ctl_pins = 2'd3;
        idle(5);
        ctl_pins = 2'd0;
        idle(20);
        begin
            int bad = 0;
            for (int c = 0; c < 100; c++) begin
                @(negedge clk);
                if (out_clk[0] === out_clk[1]) bad++;
            end
            check(bad == 0, "R4 inverted output is complement", bad, 0);
        end
        expect_period(1, 5, 5, "R4 inverted pass-through src3");

        // R5 / R6 / R1 invalid select
        set_out(3, 0, 0, 0, 1);
        set_out(4, 0, 2, 0, 0);
        set_out(5, 6, 1, 0, 1);
        idle(600);
        hold_check(3, 1'b0, 200, "R5 divide 0 held low");
        hold_check(4, 1'b0, 200, "R6 disabled output low");
        hold_check(5, 1'b0, 200, "R1 select 6 static low");

        // R7 force low
        ctl_pins = 2'd1;
        idle(3);
        begin
            int bad = 0;
            for (int c = 0; c < 50; c++) begin
                @(negedge clk);
                if (out_clk !== '0 || out_oe !== 6'h3f) bad++;
            end
            check(bad == 0, "R7 force low with enables high", bad, 0);
        end

        // R8 high impedance, clocks still running
        ctl_pins = 2'd2;
        idle(3);
        begin
            int bad = 0;
            int flips = 0;
            logic last;
            last = out_clk[0];
            for (int c = 0; c < 50; c++) begin
                @(negedge clk);
                if (out_oe !== '0) bad++;
                if (out_clk[0] !== last) flips++;
                last = out_clk[0];
            end
            check(bad == 0, "R8 enables released", bad, 0);
            check(flips > 0, "R8 divider keeps running", flips, 1);
        end

        // R9 power down
        ctl_pins = 2'd3;
        idle(3);
        begin
            int bad = 0;
            for (int c = 0; c < 50; c++) begin
                @(negedge clk);
                if (out_clk !== '0 || out_oe !== '0) bad++;
            end
            check(bad == 0, "R9 power down clocks and enables low", bad, 0);
        end
        ctl_pins = 2'd0;

        // R10 bypass: code3 -> bypass
        wr(13, 'h42);
        set_out(2, 0, 2, 0, 1);
        idle(700);
        ctl_pins = 2'd3;
        idle(100);
        expect_period(2, 2 * REF_HALF, 2 * REF_HALF, "R10 bypass uses reference");
        ctl_pins = 2'd0;
        idle(100);
        expect_period(2, 4, 4, "R10 normal after bypass");

        // R11: ratio change written during a high phase
        set_out(2, 0, 5, 0, 1);
        idle(700);
        begin
            int bad = 0;
            int npulse = 0;
            int run;
            @(negedge clk);
            while (out_clk[2] !== 1'b0) @(negedge clk);
            while (out_clk[2] !== 1'b1) @(negedge clk);
            run = 1;
            for (int c = 0; c < 300; c++) begin
                if (c == 2) begin wr_en = 1'b1; wr_addr = 4'd4; wr_data = 8'd2; end
                if (c == 3) wr_en = 1'b0;
                @(negedge clk);
                if (out_clk[2] === 1'b1) begin
                    run++;
                end else begin
                    if (run != 0) begin
                        npulse++;
                        if (run != 10 && run != 4) bad++;
                    end
                    run = 0;
                end
            end
            check(bad == 0, "R11 no short high pulse on switch", bad, 0);
            check(npulse > 5, "R11 pulses observed", npulse, 6);
        end
        expect_period(2, 4, 4, "R11 new ratio active");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule